// File: doc/BRIEF.md
# ATA Task-File Address Decoder

This block sits between a host access port and a small task-file register model for a removable ATA storage card. Each host access carries an offset into the card's common-memory or I/O window. A 6-bit mode field, supplied by the card's configuration block, decides how that offset is folded into a 4-bit task-file index. Four remapping schemes are supported: a memory-mapped layout with a large data alias window, a contiguous 16-byte I/O layout, and the two legacy fixed I/O layouts (primary and secondary), each with a command block and a control block.

After translation, the block serves the 16-bit data port, the shared Error/Features register and the ordinary task-file registers from its internal model. It implements locally the alternate-status read, the device-control write (with soft reset) and a synthesized drive-address read. It also holds a one-byte latch for odd-byte writes together with a byte-cycle flag. A write to a command-block register while the configuration block reports power-down raises a one-cycle wake request, which tells that block to leave power-down and to flag the card as ready.

All state is registered. Read data appears on `hostRdata` one clock after a read strobe and holds until the next read. Write effects and the one-cycle pulses appear one clock after a write strobe.

Top module: `ata_taskfile_decoder`

## Requirements
- R1: After reset, `hostRdata`, `devCtl`, `byteCycle`, `softReset`, `clearPowerDown` and `setCardReady` are all zero, and every task-file register, the data word and the odd-byte latch hold zero.
- R2: With mode 0, any offset from 0x400 to 0x7FF is translated to index 0 (the data port); every other offset is used unchanged as the index.
- R3: With mode 1, the index is the low 4 bits of the offset.
- R4: With mode 2, offsets 0x1F0–0x1FF map to index offset−0x1F0, offsets 0x3F0–0x3FF map to offset−0x3E8, and other offsets pass unchanged.
- R5: With mode 3, offsets 0x170–0x17F map to offset−0x170, offsets 0x370–0x37F map to offset−0x368, and other offsets pass unchanged. Any mode value above 3 passes the offset unchanged.
- R6: Indices 0x0 and 0x8 both access one 16-bit data word: a write stores all 16 bits and a read returns them. Read data appears one clock after the read strobe and holds while no read is made.
- R7: Index 0xD accesses task-file register 1 (the register behind index 0x1). Reads and writes return the low 8 bits zero-extended. Indices 0x1–0x7 are 8-bit registers read back the same way.
- R8: A read of index 0xE returns register 7 (the status byte) when `drivePresent` is 1, and 0 when it is 0.
- R9: A write to index 0xE loads `devCtl` with the low byte of the data. If data bit 2 is set, the block performs a soft reset instead. The soft reset clears `devCtl`, all task-file registers, the data word, the odd-byte latch and `byteCycle`, and pulses `softReset` for one cycle.
- R10: A read of index 0xF returns 0xC2 | ((~s << 2) & 0x3C), where s is bit 4 of register 6. This gives 0xFE for s=0 and 0xFA for s=1. Writes to 0xF are ignored.
- R11: A write to index 0x9 stores the low data byte in the odd-byte latch and toggles `byteCycle`. A read of 0x9 returns the latch zero-extended.
- R12: A write to index 0x1–0x7 while `powerDownIn` is 1 raises `clearPowerDown` and `setCardReady` for one cycle, and the write still takes effect. Writes through index 0xD, or made while `powerDownIn` is 0, raise neither.
- R13: Indices 0xA–0xC and any translated index of 0x10 or more read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modeSel | input | 6 | Address remapping mode from the configuration block |
| hostAddr | input | 11 | Host offset within the card window |
| hostRd | input | 1 | Read strobe, one cycle per access |
| hostWr | input | 1 | Write strobe, one cycle per access |
| hostWdata | input | 16 | Write data |
| drivePresent | input | 1 | A drive is attached behind the task file |
| powerDownIn | input | 1 | Power-down state held by the configuration block |
| hostRdata | output | 16 | Registered read data |
| devCtl | output | 8 | Device-control byte |
| byteCycle | output | 1 | Byte-cycle flag toggled by odd-byte writes |
| softReset | output | 1 | One-cycle soft-reset pulse |
| clearPowerDown | output | 1 | One-cycle request to leave power-down |
| setCardReady | output | 1 | One-cycle request to flag card ready |

## Verification
Read data and every write effect are due on the first rising edge after the strobe. The bench raises each strobe on a falling edge, drops it on the next falling edge, and samples the outputs right there, half a cycle after the edge that registered them. The pulses are captured in that same half-cycle window, because they are gone one cycle later. A read sweep covers every mode against windows around each remap boundary, and its expected indices come from arithmetic on the offset alone.

// File: rtl/atadec_pkg.sv
package atadec_pkg;

  // Remap mode codes carried by the mode field.
  localparam int MODE_MEM    = 0;
  localparam int MODE_CONTIG = 1;
  localparam int MODE_PRI    = 2;
  localparam int MODE_SEC    = 3;

  // Task-file index layout after translation.
  localparam int IDX_W       = 4;
  localparam int TF_SEL_W    = 3;
  localparam int IDX_DATA_LO = 4'h0;
  localparam int IDX_DATA_HI = 4'h8;
  localparam int IDX_ODD     = 4'h9;
  localparam int IDX_FEAT    = 4'hD;
  localparam int IDX_ALTCTL  = 4'hE;
  localparam int IDX_DADDR   = 4'hF;

  // Fields the block decodes out of the register model.
  localparam int DEVHEAD_REG = 6;
  localparam int STATUS_REG  = 7;
  localparam int DRV_BIT     = 4;
  localparam int SRST_BIT    = 2;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_DATA,
    RD_TF,
    RD_ALT,
    RD_DADDR,
    RD_ODD
  } rdSrc_e;

  typedef struct packed {
    logic                rdEn;
    rdSrc_e              rdSrc;
    logic [TF_SEL_W-1:0] tfSel;
    logic                wrData;
    logic                wrOdd;
    logic                wrTf;
    logic                wrDevCtl;
    logic                srst;
    logic                wake;
  } strobe_t;

endpackage

// File: rtl/atadec_remap.sv
module atadec_remap
  import atadec_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int MODE_W = 6
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] idx
);

  localparam int WINDOWS   = 2;
  localparam int BLK_LSB   = 4;
  localparam int PAGE_LSB  = 10;
  localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'((1 << BLK_LSB) - 1);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << IDX_W) - 1);

  // Mode 0: the second 1 KiB page aliases onto the data port.
  logic memAlias;
  assign memAlias = (addr >> PAGE_LSB) == ADDR_W'(1);

  // One translator per legacy I/O layout; the control block sits 0x200
  // above the command block and folds onto indices 8 and up.
  logic [ADDR_W-1:0] winIdx [WINDOWS];

  for (genvar g = 0; g < WINDOWS; g++) begin : g_win
    localparam logic [ADDR_W-1:0] CMD_BASE = (g == 0) ? ADDR_W'(32'h1F0) : ADDR_W'(32'h170);
    localparam logic [ADDR_W-1:0] CTL_BASE = CMD_BASE + ADDR_W'(32'h200);
    localparam logic [ADDR_W-1:0] CTL_OFS  = CTL_BASE - ADDR_W'(8);
    logic [ADDR_W-1:0] mapped;
    always_comb begin
      if ((addr & BLK_MASK) == CTL_BASE)      mapped = addr - CTL_OFS;
      else if ((addr & BLK_MASK) == CMD_BASE) mapped = addr - CMD_BASE;
      else                                    mapped = addr;
    end
    assign winIdx[g] = mapped;
  end

  always_comb begin
    unique case (mode)
      MODE_W'(MODE_MEM):    idx = memAlias ? '0 : addr;
      MODE_W'(MODE_CONTIG): idx = addr & LOW_MASK;
      MODE_W'(MODE_PRI):    idx = winIdx[0];
      MODE_W'(MODE_SEC):    idx = winIdx[1];
      default:              idx = addr;
    endcase
  end

endmodule

// File: rtl/atadec_ctrl.sv
module atadec_ctrl
  import atadec_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] idx,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              srstReq,
  input  logic              powerDownIn,
  output strobe_t           stb
);

  localparam int IDX_SPAN = 1 << IDX_W;

  logic              inRange;
  logic [IDX_W-1:0]  nib;

  assign inRange = idx < ADDR_W'(IDX_SPAN);
  assign nib     = idx[IDX_W-1:0];

  always_comb begin
    stb       = '0;
    stb.rdEn  = hostRd;
    stb.rdSrc = RD_ZERO;
    if (inRange) begin
      unique case (nib)
        IDX_W'(IDX_DATA_LO), IDX_W'(IDX_DATA_HI): begin
          stb.rdSrc  = RD_DATA;
          stb.wrData = hostWr;
        end
        IDX_W'(IDX_ODD): begin
          stb.rdSrc = RD_ODD;
          stb.wrOdd = hostWr;
        end
        IDX_W'(IDX_FEAT): begin
          stb.rdSrc = RD_TF;
          stb.tfSel = TF_SEL_W'(1);
          stb.wrTf  = hostWr;
        end
        IDX_W'(IDX_ALTCTL): begin
          stb.rdSrc    = RD_ALT;
          stb.wrDevCtl = hostWr & ~srstReq;
          stb.srst     = hostWr & srstReq;
        end
        IDX_W'(IDX_DADDR): begin
          stb.rdSrc = RD_DADDR;
        end
        IDX_W'(1), IDX_W'(2), IDX_W'(3), IDX_W'(4),
        IDX_W'(5), IDX_W'(6), IDX_W'(7): begin
          stb.rdSrc = RD_TF;
          stb.tfSel = nib[TF_SEL_W-1:0];
          stb.wrTf  = hostWr;
          stb.wake  = hostWr & powerDownIn;
        end
        default: stb.rdSrc = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/atadec_dp.sv
module atadec_dp
  import atadec_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_W   = 8,
  parameter int TF_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              drivePresent,
  output logic [DATA_W-1:0] hostRdata,
  output logic [REG_W-1:0]  devCtl,
  output logic              byteCycle,
  output logic              softReset,
  output logic              wakePulse
);

  localparam logic [REG_W-1:0] DADDR_BASE = REG_W'(8'hC2);
  localparam logic [REG_W-1:0] DADDR_MASK = REG_W'(8'h3C);

  logic [REG_W-1:0]  tfVal [TF_REGS];
  logic [DATA_W-1:0] dataWord;
  logic [REG_W-1:0]  oddByte;
  logic [DATA_W-1:0] rdMux;
  logic              drvSel;
  logic [REG_W-1:0]  drvAddr;

  assign tfVal[0] = '0;

  for (genvar i = 1; i < TF_REGS; i++) begin : g_tf
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       q <= '0;
      else if (stb.srst)                                q <= '0;
      else if (stb.wrTf && stb.tfSel == TF_SEL_W'(i))   q <= hostWdata[REG_W-1:0];
    end
    assign tfVal[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataWord  <= '0;
      oddByte   <= '0;
      byteCycle <= 1'b0;
      devCtl    <= '0;
    end else if (stb.srst) begin
      dataWord  <= '0;
      oddByte   <= '0;
      byteCycle <= 1'b0;
      devCtl    <= '0;
    end else begin
      if (stb.wrData)   dataWord <= hostWdata;
      if (stb.wrOdd) begin
        oddByte   <= hostWdata[REG_W-1:0];
        byteCycle <= ~byteCycle;
      end
      if (stb.wrDevCtl) devCtl <= hostWdata[REG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      softReset <= 1'b0;
      wakePulse <= 1'b0;
    end else begin
      softReset <= stb.srst;
      wakePulse <= stb.wake;
    end
  end

  assign drvSel  = tfVal[DEVHEAD_REG][DRV_BIT];
  assign drvAddr = DADDR_BASE | ((~REG_W'(drvSel) << 2) & DADDR_MASK);

  always_comb begin
    unique case (stb.rdSrc)
      RD_DATA:  rdMux = dataWord;
      RD_TF:    rdMux = DATA_W'(tfVal[stb.tfSel]);
      RD_ALT:   rdMux = drivePresent ? DATA_W'(tfVal[STATUS_REG]) : '0;
      RD_DADDR: rdMux = DATA_W'(drvAddr);
      RD_ODD:   rdMux = DATA_W'(oddByte);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hostRdata <= '0;
    else if (stb.rdEn) hostRdata <= rdMux;
  end

endmodule

// File: rtl/ata_taskfile_decoder.sv
module ata_taskfile_decoder
  import atadec_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int MODE_W  = 6,
  parameter int DATA_W  = 16,
  parameter int REG_W   = 8,
  parameter int TF_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              drivePresent,
  input  logic              powerDownIn,
  output logic [DATA_W-1:0] hostRdata,
  output logic [REG_W-1:0]  devCtl,
  output logic              byteCycle,
  output logic              softReset,
  output logic              clearPowerDown,
  output logic              setCardReady
);

  logic [ADDR_W-1:0] tfIdx;
  strobe_t           stb;
  logic              wakePulse;

  atadec_remap #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_remap (
    .mode (modeSel),
    .addr (hostAddr),
    .idx  (tfIdx)
  );

  atadec_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .idx         (tfIdx),
    .hostRd      (hostRd),
    .hostWr      (hostWr),
    .srstReq     (hostWdata[SRST_BIT]),
    .powerDownIn (powerDownIn),
    .stb         (stb)
  );

  atadec_dp #(.DATA_W(DATA_W), .REG_W(REG_W), .TF_REGS(TF_REGS)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .hostWdata    (hostWdata),
    .drivePresent (drivePresent),
    .hostRdata    (hostRdata),
    .devCtl       (devCtl),
    .byteCycle    (byteCycle),
    .softReset    (softReset),
    .wakePulse    (wakePulse)
  );

  assign clearPowerDown = wakePulse;
  assign setCardReady   = wakePulse;

endmodule

// File: rtl/atadec_checker.sv
module atadec_checker #(
  parameter int ADDR_W = 11,
  parameter int MODE_W = 6,
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] modeSel,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hostRd,
  input logic              hostWr,
  input logic [DATA_W-1:0] hostWdata,
  input logic              powerDownIn,
  input logic [DATA_W-1:0] hostRdata,
  input logic [REG_W-1:0]  devCtl,
  input logic              byteCycle,
  input logic              softReset,
  input logic              clearPowerDown
);

  // R1: an edge taken in reset leaves every output at zero
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (hostRdata == '0 && devCtl == '0 && !byteCycle && !softReset && !clearPowerDown));

  // R6: read data only moves after a read strobe
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hostRd) |-> $stable(hostRdata));

  // R9: a soft-reset pulse follows a write carrying the reset bit and leaves state cleared
  p_srst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    softReset |-> $past(hostWr && hostWdata[2]));
  p_srst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    softReset |-> (devCtl == '0 && !byteCycle));

  // R11: the byte-cycle flag only moves after a write
  p_cycle_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byteCycle) |-> $past(hostWr));

  // R12: a wake request needs a write made during power-down
  p_wake_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clearPowerDown |-> $past(hostWr && powerDownIn));

  // R12: the wake request lasts a single cycle for a single write
  p_wake_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clearPowerDown && !$past(hostWr)) |=> !clearPowerDown);

endmodule

bind ata_taskfile_decoder atadec_checker #(
  .ADDR_W(ADDR_W), .MODE_W(MODE_W), .DATA_W(DATA_W), .REG_W(REG_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .modeSel        (modeSel),
  .hostAddr       (hostAddr),
  .hostRd         (hostRd),
  .hostWr         (hostWr),
  .hostWdata      (hostWdata),
  .powerDownIn    (powerDownIn),
  .hostRdata      (hostRdata),
  .devCtl         (devCtl),
  .byteCycle      (byteCycle),
  .softReset      (softReset),
  .clearPowerDown (clearPowerDown)
);

// File: tb/sim_ata_taskfile_decoder.sv
`timescale 1ns/1ps
module sim_ata_taskfile_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  modeSel = '0;
  logic [10:0] hostAddr = '0;
  logic        hostRd = 1'b0;
  logic        hostWr = 1'b0;
  logic [15:0] hostWdata = '0;
  logic        drivePresent = 1'b1;
  logic        powerDownIn = 1'b0;
  logic [15:0] hostRdata;
  logic [7:0]  devCtl;
  logic        byteCycle;
  logic        softReset;
  logic        clearPowerDown;
  logic        setCardReady;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Expected-state model built from the requirements.
  logic [7:0]  mTf [8];
  logic [15:0] mData;
  logic [7:0]  mOdd;
  logic        mCycle;
  logic [7:0]  mDev;
  logic        seenWake, seenCard, seenSrst;

  always #2 clk = ~clk;

  ata_taskfile_decoder u0 (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .hostAddr(hostAddr),
    .hostRd(hostRd), .hostWr(hostWr), .hostWdata(hostWdata),
    .drivePresent(drivePresent), .powerDownIn(powerDownIn),
    .hostRdata(hostRdata), .devCtl(devCtl), .byteCycle(byteCycle),
    .softReset(softReset), .clearPowerDown(clearPowerDown),
    .setCardReady(setCardReady)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int remapIdx(input int mode, input int a);
    case (mode)
      0: return (a >= 'h400 && a <= 'h7FF) ? 0 : a;
      1: return a % 16;
      2: if (a >= 'h3F0 && a <= 'h3FF) return a - 'h3E8;
         else if (a >= 'h1F0 && a <= 'h1FF) return a - 'h1F0;
         else return a;
      3: if (a >= 'h370 && a <= 'h37F) return a - 'h368;
         else if (a >= 'h170 && a <= 'h17F) return a - 'h170;
         else return a;
      default: return a;
    endcase
  endfunction

  function automatic logic [15:0] expRead(input int idx);
    logic [7:0] s;
    if (idx > 15) return 16'h0;
    case (idx)
      0, 8: return mData;
      1, 2, 3, 4, 5, 6, 7: return {8'h00, mTf[idx]};
      'hD: return {8'h00, mTf[1]};
      9: return {8'h00, mOdd};
      'hE: return drivePresent ? {8'h00, mTf[7]} : 16'h0;
      'hF: begin
        s = {7'b0, mTf[6][4]};
        return {8'h00, 8'hC2 | ((~s << 2) & 8'h3C)};
      end
      default: return 16'h0;
    endcase
  endfunction

  task automatic modelWrite(input int idx, input logic [15:0] v);
    if (idx > 15) return;
    case (idx)
      0, 8: mData = v;
      1, 2, 3, 4, 5, 6, 7: mTf[idx] = v[7:0];
      'hD: mTf[1] = v[7:0];
      9: begin mOdd = v[7:0]; mCycle = ~mCycle; end
      'hE: begin
        if (v[2]) begin
          for (int k = 0; k < 8; k++) mTf[k] = 8'h00;
          mData = '0; mOdd = '0; mCycle = 1'b0; mDev = '0;
        end else mDev = v[7:0];
      end
      default: ;
    endcase
  endtask

  task automatic doRead(input int a, output logic [15:0] r);
    @(negedge clk);
    hostAddr = 11'(a); hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    r = hostRdata;
  endtask

  task automatic doWrite(input int a, input logic [15:0] v);
    @(negedge clk);
    hostAddr = 11'(a); hostWdata = v; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
    seenWake = clearPowerDown;
    seenCard = setCardReady;
    seenSrst = softReset;
    modelWrite(remapIdx(int'(modeSel), a), v);
  endtask

  task automatic readCheck(input string req, input int a);
    logic [15:0] r;
    doRead(a, r);
    check(req, {16'h0, r}, {16'h0, expRead(remapIdx(int'(modeSel), a))});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int modes [5] = '{0, 1, 2, 3, 9};
    for (int k = 0; k < 8; k++) mTf[k] = 8'h00;
    mData = '0; mOdd = '0; mCycle = 1'b0; mDev = '0;
    seenWake = 0; seenCard = 0; seenSrst = 0;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdata", {16'h0, hostRdata}, 0);
    check("R1 devCtl", {24'h0, devCtl}, 0);
    check("R1 pulses", {29'h0, byteCycle, softReset, clearPowerDown}, 0);
    rst_n = 1'b1;
    check("R1 cardReady", {31'h0, setCardReady}, 0);

    // Preload registers through the contiguous layout (R3).
    modeSel = 6'd1;
    for (int i = 1; i < 8; i++) doWrite(i, 16'(i * 17));
    doWrite(0, 16'hBEEF);
    doWrite(9, 16'h125A);
    check("R11 cycle toggled", {31'h0, byteCycle}, {31'h0, mCycle});
    check("R11 cycle set", {31'h0, byteCycle}, 1);

    // R2 R3 R4 R5 R6 R7 R8 R10 R11 R13: read sweep over every mode
    for (int m = 0; m < 5; m++) begin
      modeSel = 6'(modes[m]);
      for (int a = 0; a < 'h20; a++) readCheck("R2-sweep low window", a);
      for (int a = 'h170; a < 'h180; a++) readCheck("R5 secondary command", a);
      for (int a = 'h1F0; a < 'h200; a++) readCheck("R4 primary command", a);
      for (int a = 'h370; a < 'h380; a++) readCheck("R5 secondary control", a);
      for (int a = 'h3F0; a < 'h400; a++) readCheck("R4 primary control", a);
      readCheck("R2 alias start", 'h400);
      readCheck("R2 alias mid", 'h5A5);
      readCheck("R2 alias end", 'h7FF);
      readCheck("R13 out of range", 'h100);
      readCheck("R13 out of range", 'h2F0);
    end

    // R2: a write inside the alias page lands on the data word
    modeSel = 6'd0;
    doWrite('h6AB, 16'h4321);
    doRead(0, r);
    check("R2 alias write", {16'h0, r}, 32'h4321);
    // R6: index 8 shares the data word
    doWrite(8, 16'hA55A);
    doRead(0, r);
    check("R6 data via 8", {16'h0, r}, 32'hA55A);

    // R4 / R5: writes through the legacy layouts
    modeSel = 6'd2;
    doWrite('h1F2, 16'h0033);
    modeSel = 6'd3;
    doWrite('h174, 16'h0044);
    modeSel = 6'd1;
    doRead(2, r);
    check("R4 primary write", {16'h0, r}, 32'h33);
    doRead(4, r);
    check("R5 secondary write", {16'h0, r}, 32'h44);

    // R8: alternate status with and without a drive
    doRead('hE, r);
    check("R8 status present", {16'h0, r}, {16'h0, expRead('hE)});
    drivePresent = 1'b0;
    doRead('hE, r);
    check("R8 no drive", {16'h0, r}, 0);
    drivePresent = 1'b1;

    // R10: drive address for both select values
    doWrite(6, 16'h0066);
    doRead('hF, r);
    check("R10 select 0", {16'h0, r}, 32'hFE);
    doWrite(6, 16'h0076);
    doRead('hF, r);
    check("R10 select 1", {16'h0, r}, 32'hFA);
    doWrite('hF, 16'h00FF);
    doRead(6, r);
    check("R10 write ignored", {16'h0, r}, 32'h76);

    // R7 and R12: Features write during power-down does not wake
    powerDownIn = 1'b1;
    doWrite('hD, 16'h003C);
    check("R12 no wake via D", {30'h0, seenWake, seenCard}, 0);
    doRead(1, r);
    check("R7 shared reg1", {16'h0, r}, 32'h3C);
    doWrite(3, 16'h0099);
    check("R12 wake", {30'h0, seenWake, seenCard}, 3);
    @(negedge clk);
    check("R12 single pulse", {31'h0, clearPowerDown}, 0);
    doRead(3, r);
    check("R12 write kept", {16'h0, r}, 32'h99);
    powerDownIn = 1'b0;
    doWrite(3, 16'h0098);
    check("R12 no wake awake", {30'h0, seenWake, seenCard}, 0);

    // R13: unmapped and out-of-range writes change nothing
    doWrite('hB, 16'h00EE);
    doRead('hB, r);
    check("R13 unmapped", {16'h0, r}, 0);
    modeSel = 6'd2;
    doWrite('h3F9, 16'h00EE);
    modeSel = 6'd1;
    for (int i = 0; i < 16; i++) readCheck("R13 state intact", i);

    // R11: second odd write toggles back
    doWrite(9, 16'h00C3);
    check("R11 cycle back", {31'h0, byteCycle}, 0);
    doRead(9, r);
    check("R11 latch", {16'h0, r}, 32'hC3);

    // R9: device control load, then soft reset
    doWrite('hE, 16'h0002);
    check("R9 devCtl", {24'h0, devCtl}, 32'h02);
    check("R9 no srst", {31'h0, seenSrst}, 0);
    doWrite(9, 16'h0011);
    doWrite('hE, 16'h0006);
    check("R9 srst pulse", {31'h0, seenSrst}, 1);
    check("R9 devCtl cleared", {24'h0, devCtl}, 0);
    check("R9 cycle cleared", {31'h0, byteCycle}, 0);
    for (int i = 0; i < 16; i++) readCheck("R9 regs cleared", i);
    @(negedge clk);
    check("R9 single pulse", {31'h0, softReset}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule